// File: doc/BRIEF.md
# ECC Step Status Aggregator

After a page has been read and decoded, the error-correction engine leaves one 64-bit status word per correction step. This block consumes those words in step order, one per clock when offered, and reduces them to a page-level summary. The summary holds the worst bitflip count of any correctable step and the sum of corrected bits. It also counts the uncorrectable steps and carries a flag that marks the page as blank. Software or a sequencer uses this summary to decide whether the page read succeeded, needs scrubbing, or should be treated as a blank page.

A start pulse clears the summary and arms the block. Words then arrive with a valid strobe, and the final one carries a last marker. The block never stalls its input. When the scrambler is enabled, an uncorrectable step whose count of zero bits is below the configured correction strength means the page was never programmed. In that case the block stops at once and reports the page as erased instead of failed. A one-cycle done pulse marks the moment the summary is final. The summary then stays frozen until the next start.

Top module: `ecc_page_summary`

## Requirements
- R1: After reset, and in the cycle after `start_i`, the outputs `max_flips_o`, `corrected_o` and `failed_o` are zero and `erased_o`, `not_ready_o` and `done_o` are low.
- R2: Each status word is decoded from fixed positions: bit 31 is the step-complete flag, bits 29:24 hold the 6-bit error count, and bits 21:16 hold the 6-bit zero-bit count. All other bits, including the two user bytes in bits 15:0, have no effect on the summary.
- R3: A complete step whose error count is not 63 adds its error count to `corrected_o`.
- R4: `max_flips_o` equals the largest error count among the correctable steps accepted since the last start.
- R5: A complete step with error count 63 that does not meet the erased condition increments `failed_o`, adds nothing to `corrected_o`, and processing continues with the next word.
- R6: A complete step with error count 63 is an erased condition when `scramble_en_i` is high and its zero-bit count is strictly less than `strength_i`. Then `erased_o` is set, `done_o` pulses in the next cycle, and any later words are ignored until the next start.
- R7: With `scramble_en_i` low, or with a zero-bit count equal to or above `strength_i`, an error count of 63 is counted as failed and never sets `erased_o`.
- R8: A word with bit 31 clear sets `not_ready_o` and changes neither `corrected_o`, `max_flips_o` nor `failed_o`.
- R9: `done_o` is high for exactly one cycle, in the cycle right after the word marked last is accepted, and the summary outputs are final in that same cycle.
- R10: Between the end of a page and the next start, the summary outputs hold their values, and offered words are ignored and raise no `done_o`.
- R11: A word offered in the same cycle as `start_i` is dropped, and the clear takes effect.
- R12: `corrected_o` and `failed_o` saturate at their all-ones value and do not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clears the summary and arms the block for a new page |
| word_valid_i | input | 1 | A status word is offered this cycle |
| word_last_i | input | 1 | The offered word is the final step of the page |
| word_i | input | 64 | Per-step status word |
| strength_i | input | 6 | Correction strength used for the erased-page test |
| scramble_en_i | input | 1 | Scrambler enabled for this page |
| max_flips_o | output | 6 | Largest correctable error count seen |
| corrected_o | output | TOTAL_W | Saturating sum of corrected bits |
| failed_o | output | FAIL_W | Saturating count of uncorrectable steps |
| erased_o | output | 1 | Page detected as blank |
| not_ready_o | output | 1 | A step arrived with its complete flag clear |
| done_o | output | 1 | One-cycle pulse when the summary is final |

## Verification
The bench builds the block with `MAX_STEPS` = 4. This gives a 9-bit corrected total and a 3-bit failed count. Nine uncorrectable steps then reach the failed-count ceiling, and nine steps of 62 flips go past the 511 ceiling of the total, so both saturation limits are exercised in a short run. The strength is set to 8, so zero-bit counts of 7 and 8 sit exactly on either side of the erased threshold.

// File: rtl/ecc_sum_pkg.sv
// Shared constants and types for the ECC step status aggregator.
// Assumes a 64-bit status word whose field positions are fixed by the
// decoder that writes it.
package ecc_sum_pkg;
    localparam int unsigned WORD_W   = 64;
    localparam int unsigned CNT_W    = 6;
    localparam int unsigned FLAG_BIT = 31;
    localparam int unsigned ERR_LSB  = 24;
    localparam int unsigned ZERO_LSB = 16;

    typedef enum logic [1:0] {
        STEP_OK    = 2'd0,
        STEP_BAD   = 2'd1,
        STEP_BLANK = 2'd2,
        STEP_STALE = 2'd3
    } step_kind_e;
endpackage

// File: rtl/ecc_step_decode.sv
// Classifies one status word: stale (not complete), correctable,
// uncorrectable, or blank-page evidence. Purely combinational.
// Assumes strength and scrambler setting are stable while a word is offered.
module ecc_step_decode
    import ecc_sum_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  strength_i,
    input  logic              scramble_en_i,
    output logic [CNT_W-1:0]  err_o,
    output step_kind_e        kind_o
);
    logic             complete;
    logic [CNT_W-1:0] zero_cnt;
    logic             unused_bits;

    assign unused_bits = ^{word_i[WORD_W-1:32], word_i[30], word_i[23:22], word_i[15:0]};

    // Extract fields and pick the step class, stale taking precedence.
    always_comb begin
        complete = word_i[FLAG_BIT];
        err_o    = word_i[ERR_LSB +: CNT_W];
        zero_cnt = word_i[ZERO_LSB +: CNT_W];
        if (!complete)
            kind_o = STEP_STALE;
        else if (err_o != {CNT_W{1'b1}})
            kind_o = STEP_OK;
        else if (scramble_en_i && (zero_cnt < strength_i))
            kind_o = STEP_BLANK;
        else
            kind_o = STEP_BAD;
    end
endmodule

// File: rtl/ecc_sum_accum.sv
// Holds the page summary registers and updates them for one accepted step.
// Assumes clear_i and step_en_i are never both set (the top gates this).
module ecc_sum_accum
    import ecc_sum_pkg::*;
#(
    parameter int unsigned TOTAL_W = 11,
    parameter int unsigned FAIL_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               step_en_i,
    input  step_kind_e         kind_i,
    input  logic [CNT_W-1:0]   err_i,
    output logic [CNT_W-1:0]   max_o,
    output logic [TOTAL_W-1:0] total_o,
    output logic [FAIL_W-1:0]  failed_o,
    output logic               erased_o,
    output logic               stale_o
);
    localparam int unsigned PAD_W = TOTAL_W + 1 - CNT_W;

    logic [TOTAL_W:0] sum_ext;

    // Widened sum for saturation detection.
    always_comb begin
        sum_ext = {1'b0, total_o} + {{PAD_W{1'b0}}, err_i};
    end

    // Clear on reset or start, otherwise fold in the accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            max_o    <= '0;
            total_o  <= '0;
            failed_o <= '0;
            erased_o <= 1'b0;
            stale_o  <= 1'b0;
        end else if (step_en_i) begin
            case (kind_i)
                STEP_OK: begin
                    total_o <= sum_ext[TOTAL_W] ? {TOTAL_W{1'b1}} : sum_ext[TOTAL_W-1:0];
                    if (err_i > max_o)
                        max_o <= err_i;
                end
                STEP_BAD: begin
                    if (!(&failed_o))
                        failed_o <= failed_o + 1'b1;
                end
                STEP_BLANK: erased_o <= 1'b1;
                default:    stale_o  <= 1'b1;
            endcase
        end
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (total_o == '0 && failed_o == '0 && max_o == '0 && !erased_o && !stale_o));

    assert_total_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !clear_i && kind_i == STEP_OK) |=> (total_o >= $past(total_o)));

    assert_max_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !clear_i && kind_i == STEP_OK) |=> (max_o >= $past(err_i)));

    assert_fail_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !clear_i && kind_i == STEP_BAD && !(&failed_o))
        |=> (failed_o == $past(failed_o) + 1'b1) && $stable(total_o));

    assert_stale_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !clear_i && kind_i == STEP_STALE)
        |=> stale_o && $stable(total_o) && $stable(failed_o) && $stable(max_o));

    assert_fail_saturates_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en_i && !clear_i && kind_i == STEP_BAD && (&failed_o)) |=> (&failed_o));
endmodule

// File: rtl/ecc_page_summary.sv
// Page-level ECC summary: arms on start, accepts one status word per valid
// cycle, ends on the last word or on blank-page evidence, pulses done.
// Assumes the input never needs backpressure; words offered while idle
// are dropped.
module ecc_page_summary
    import ecc_sum_pkg::*;
#(
    parameter  int unsigned MAX_STEPS = 16,
    localparam int unsigned TOTAL_W   = CNT_W + $clog2(MAX_STEPS + 1),
    localparam int unsigned FAIL_W    = $clog2(MAX_STEPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               word_valid_i,
    input  logic               word_last_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic [CNT_W-1:0]   strength_i,
    input  logic               scramble_en_i,
    output logic [CNT_W-1:0]   max_flips_o,
    output logic [TOTAL_W-1:0] corrected_o,
    output logic [FAIL_W-1:0]  failed_o,
    output logic               erased_o,
    output logic               not_ready_o,
    output logic               done_o
);
    logic             active_q;
    logic             accept;
    logic             finish;
    logic [CNT_W-1:0] step_err;
    step_kind_e       step_kind;

    ecc_step_decode u_decode (
        .word_i        (word_i),
        .strength_i    (strength_i),
        .scramble_en_i (scramble_en_i),
        .err_o         (step_err),
        .kind_o        (step_kind)
    );

    ecc_sum_accum #(
        .TOTAL_W (TOTAL_W),
        .FAIL_W  (FAIL_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .step_en_i (accept),
        .kind_i    (step_kind),
        .err_i     (step_err),
        .max_o     (max_flips_o),
        .total_o   (corrected_o),
        .failed_o  (failed_o),
        .erased_o  (erased_o),
        .stale_o   (not_ready_o)
    );

    // Accept only while armed; a start in the same cycle drops the word.
    always_comb begin
        accept = active_q && word_valid_i && !start_i;
        finish = accept && (word_last_i || step_kind == STEP_BLANK);
    end

    // Arm on start, disarm on the final or blank step, pulse done after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= finish;
            if (start_i)
                active_q <= 1'b1;
            else if (finish)
                active_q <= 1'b0;
        end
    end

    assert_erased_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erased_o) |-> done_o);

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && word_last_i) |=> done_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !start_i) |=> ($stable(corrected_o) && $stable(failed_o) &&
            $stable(max_flips_o) && $stable(erased_o) && $stable(not_ready_o) && !done_o));

    assert_start_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && word_valid_i) |=> (corrected_o == '0 && failed_o == '0 && !done_o));
endmodule

// File: tb/test_ecc_page_summary.sv
`timescale 1ns/1ps
module test_ecc_page_summary;
    localparam int unsigned STEPS = 4;
    localparam int unsigned TW    = 9;
    localparam int unsigned FW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          valid = 1'b0;
    logic          last = 1'b0;
    logic [63:0]   word = '0;
    logic [5:0]    strength = 6'd8;
    logic          scramble = 1'b0;
    logic [5:0]    max_flips;
    logic [TW-1:0] corrected;
    logic [FW-1:0] failed;
    logic          erased;
    logic          not_ready;
    logic          done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ecc_page_summary #(.MAX_STEPS(STEPS)) i_ecc_page_summary (
        .clk(clk), .rst_n(rst_n), .start_i(start), .word_valid_i(valid),
        .word_last_i(last), .word_i(word), .strength_i(strength),
        .scramble_en_i(scramble), .max_flips_o(max_flips), .corrected_o(corrected),
        .failed_o(failed), .erased_o(erased), .not_ready_o(not_ready), .done_o(done)
    );

    function automatic logic [63:0] mk(input logic c, input int err, input int zero,
                                       input logic [15:0] oob);
        logic [5:0] e = err[5:0];
        logic [5:0] z = zero[5:0];
        return {32'hDEAD_BEEF, c, 1'b1, e, 2'b10, z, oob};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic send(input logic [63:0] w, input logic l);
        @(negedge clk) begin valid = 1'b1; word = w; last = l; end
        @(negedge clk) begin valid = 1'b0; last = 1'b0; end
    endtask

    task automatic t_reset();
        chk("R1 reset corrected", corrected, 0);
        chk("R1 reset failed", failed, 0);
        chk("R1 reset max", max_flips, 0);
        chk("R1 reset erased", erased, 0);
        chk("R1 reset done", done, 0);
    endtask

    task automatic t_correctable();
        scramble = 1'b0;
        do_start();
        send(mk(1, 3, 40, 16'h1234), 0);
        send(mk(1, 7, 1, 16'hFFFF), 0);
        chk("R9 no done before last", done, 0);
        send(mk(1, 2, 0, 16'hA55A), 1);
        chk("R9 done after last", done, 1);
        chk("R3 R2 corrected sum", corrected, 12);
        chk("R4 max flips", max_flips, 7);
        chk("R5 no failures", failed, 0);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
    endtask

    task automatic t_failures();
        scramble = 1'b0;
        do_start();
        send(mk(1, 5, 0, 16'h0), 0);
        send(mk(1, 63, 0, 16'h0), 0);
        chk("R5 continues after failure", done, 0);
        send(mk(1, 4, 0, 16'h0), 1);
        chk("R5 failed count", failed, 1);
        chk("R5 corrected excludes failed", corrected, 9);
        chk("R7 scrambler off not erased", erased, 0);
        chk("R4 max after mix", max_flips, 5);
    endtask

    task automatic t_boundary();
        scramble = 1'b1;
        do_start();
        send(mk(1, 63, 8, 16'h0), 1);
        chk("R7 zero equal strength not erased", erased, 0);
        chk("R7 zero equal strength failed", failed, 1);
    endtask

    task automatic t_erased();
        scramble = 1'b1;
        do_start();
        send(mk(1, 2, 30, 16'h0), 0);
        send(mk(1, 63, 7, 16'h0), 0);
        chk("R6 erased flag", erased, 1);
        chk("R6 early done", done, 1);
        chk("R6 failed untouched", failed, 0);
        send(mk(1, 9, 0, 16'h0), 1);
        chk("R10 later word ignored", corrected, 2);
        chk("R10 no second done", done, 0);
        chk("R10 erased held", erased, 1);
    endtask

    task automatic t_not_ready();
        scramble = 1'b0;
        do_start();
        chk("R1 clear after start", erased, 0);
        send(mk(0, 20, 0, 16'h0), 0);
        chk("R8 not ready set", not_ready, 1);
        chk("R8 corrected untouched", corrected, 0);
        chk("R8 max untouched", max_flips, 0);
        send(mk(1, 1, 0, 16'h0), 1);
        chk("R8 following word counted", corrected, 1);
        do_start();
        chk("R1 not ready cleared", not_ready, 0);
    endtask

    task automatic t_start_collide();
        @(negedge clk) begin start = 1'b1; valid = 1'b1; word = mk(1, 10, 0, 16'h0); end
        @(negedge clk) begin start = 1'b0; valid = 1'b0; end
        chk("R11 colliding word dropped", corrected, 0);
        send(mk(1, 1, 0, 16'h0), 1);
        chk("R11 next word taken", corrected, 1);
        chk("R11 max", max_flips, 1);
    endtask

    task automatic t_saturate();
        scramble = 1'b0;
        do_start();
        for (int i = 0; i < 9; i++) send(mk(1, 63, 0, 16'h0), 0);
        chk("R12 failed saturates", failed, 7);
        for (int i = 0; i < 9; i++) send(mk(1, 62, 0, 16'h0), i == 8);
        chk("R12 corrected saturates", corrected, 511);
        chk("R12 max", max_flips, 62);
        chk("R9 done after long page", done, 1);
        send(mk(1, 5, 0, 16'h0), 1);
        chk("R10 idle word ignored", corrected, 511);
        chk("R10 idle no done", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_correctable();
        t_failures();
        t_boundary();
        t_erased();
        t_not_ready();
        t_start_collide();
        t_saturate();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule